// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and one external asynchronous static RAM of 128K words by 16 bits. The host offers a single-beat request (read or write, word address, write data and a per-byte enable) through a valid/ready pair. The controller turns each request into a timed sequence on the memory pins: chip enable, write enable, output enable and one strobe per byte lane, all active low. The data bus is split into an outgoing value, a drive enable and an incoming value.

Every phase length is a whole number of clock cycles. The count is rounded up from the memory's nanosecond minimums for the clock period chosen by a parameter. A second parameter selects the 70 ns or the 100 ns speed grade. Reads keep output enable low for the whole access time. The data is captured on the edge that closes the access and is returned with a one-cycle valid pulse. Writes keep output enable high. They first spend a setup phase with the bus undriven, so that a memory still releasing the bus after a read cannot clash with the controller's drivers. Then write enable is pulsed low while data is driven, and a short recovery follows. Between requests the chip is deselected so that it falls into standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While no request is in progress, `req_ready` is 1, chip enable, write enable, output enable and both byte strobes are 1, the data drivers are off and `rsp_valid` is 0. This is also the state after reset.
- R2: A read accepted on clock edge E drives chip enable and output enable low and write enable high from E for RD_CYC = ceil(tRC/CLK_NS) cycles, where tRC is 70 ns (fast grade) or 100 ns (slow grade). `rsp_valid` is 1 in exactly the cycle after edge E+RD_CYC, carrying the bus value sampled on that edge.
- R3: During a read the strobe of lane i (bit 0 = bits 7:0, bit 1 = bits 15:8) is low only when `req_be[i]` was 1. In `rsp_rdata`, a lane whose enable was 0 reads as 8'h00.
- R4: A write accepted on edge E runs three phases: WS_CYC cycles with chip enable low and write enable high, then WP_CYC cycles with write enable low, then REC_CYC cycles with write enable high. After these phases `req_ready` returns. With a 10 ns clock the counts are 3/4/1 (fast grade) and 4/6/1 (slow grade).
- R5: During a write, only the lanes whose enable bit was 1 have their strobe low. Memory bytes in the other lanes keep their earlier value.
- R6: Output enable stays high from the acceptance of a write until it ends. The data drivers are on only while write enable is low and during the recovery phase. The drivers are never on in a cycle that directly follows one with output enable low.
- R7: The memory address is loaded at acceptance. It changes only in a cycle where write enable is high and was high in the cycle before.
- R8: The phase counts come from the parameters: WS_CYC = max(1, ceil(tOHZ/CLK_NS)) with tOHZ 30/35 ns; WP_CYC = max(ceil(tWP/CLK_NS), ceil(tAW/CLK_NS) - WS_CYC) with tWP 35/50 ns and tAW 70/100 ns; REC_CYC = max(1, ceil(tWC/CLK_NS) - WS_CYC - WP_CYC). Write enable is never low for fewer than WP_CYC consecutive cycles.
- R9: While `req_ready` is 0, `req_valid` and the request fields are ignored. No extra memory cycle is started and the memory contents do not change.
- R10: `rsp_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (16) | Data for a write |
| req_be | input | DATA_W/8 (2) | Byte-lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W (16) | Read data, disabled lanes zero |
| sram_addr | output | ADDR_W (17) | Memory address bus |
| sram_dq_out | output | DATA_W (16) | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_in | input | DATA_W (16) | Value read from the data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lane_n | output | DATA_W/8 (2) | Byte-lane strobes, active low, bit 0 = low byte |

## Verification
The assertions assume that the `CLK_NS` parameter matches the real clock period. They also assume that the request fields are stable on the edge where `req_valid` meets `req_ready`, because the controller samples them only then. The stimulus changes every input half a cycle away from the active edge and keeps each request raised until it is taken. It also deliberately raises a competing request while a read is still in flight, to show that such a request is not taken. The memory model answers only when chip enable, output enable and a lane strobe are all low. It returns a junk byte on lanes whose strobe is high, so the read-data masking is observable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READ  = 3'd1,
      PH_SETUP = 3'd2,
      PH_PULSE = 3'd3,
      PH_RECOV = 3'd4
   } phase_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic sel;
      logic drive;
   } pin_ctl_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Pin levels that belong to each phase.
   function automatic pin_ctl_t phase_pins(input phase_e ph);
      pin_ctl_t p;
      p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, sel: 1'b0, drive: 1'b0};
      case (ph)
         PH_READ:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; p.sel = 1'b1; end
         PH_SETUP: begin p.ce_n = 1'b0; p.sel = 1'b1; end
         PH_PULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; end
         PH_RECOV: begin p.ce_n = 1'b0; p.sel = 1'b1; p.drive = 1'b1; end
         default:  ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
   parameter int LANES = 2
) (
   input  logic               sel,
   input  logic [LANES-1:0]   lane_en,
   input  logic [LANES*8-1:0] bus_in,
   output logic [LANES-1:0]   strobe_n,
   output logic [LANES*8-1:0] masked
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign strobe_n[i]     = ~(sel & lane_en[i]);
      assign masked[i*8 +: 8] = lane_en[i] ? bus_in[i*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 16,
   parameter int CLK_NS     = 10,
   parameter bit SLOW_GRADE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic [ADDR_W-1:0]   sram_addr,
   output logic [DATA_W-1:0]   sram_dq_out,
   output logic                sram_dq_oe,
   input  logic [DATA_W-1:0]   sram_dq_in,
   output logic                sram_ce_n,
   output logic                sram_we_n,
   output logic                sram_oe_n,
   output logic [DATA_W/8-1:0] sram_lane_n
);

   localparam int LANES   = DATA_W / 8;
   // Memory minimums in ns, per grade.
   localparam int T_RC    = SLOW_GRADE ? 100 : 70;
   localparam int T_WC    = SLOW_GRADE ? 100 : 70;
   localparam int T_AW    = SLOW_GRADE ? 100 : 70;
   localparam int T_WP    = SLOW_GRADE ? 50 : 35;
   localparam int T_DW    = SLOW_GRADE ? 40 : 30;
   localparam int T_OHZ   = SLOW_GRADE ? 35 : 30;
   // Cycle counts derived from the clock period.
   localparam int RD_CYC  = ceil_div(T_RC, CLK_NS);
   localparam int WS_CYC  = max2(1, ceil_div(T_OHZ, CLK_NS));
   localparam int WP_CYC  = max2(ceil_div(T_WP, CLK_NS), ceil_div(T_AW, CLK_NS) - WS_CYC);
   localparam int REC_CYC = max2(1, ceil_div(T_WC, CLK_NS) - WS_CYC - WP_CYC);
   localparam int MAX_CYC = max2(max2(RD_CYC, WS_CYC), max2(WP_CYC, REC_CYC));
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   // Elaboration checks on the parameter set.
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end
   if (WP_CYC * CLK_NS < T_DW) begin : g_bad_dw
      $error("write pulse shorter than the data setup window");
   end

   phase_e            phase_q, phase_d;
   pin_ctl_t          pins_q, pins_d;
   logic              phase_done;
   logic              accept;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q, be_d;
   logic [LANES-1:0]  strobe_d;
   logic [LANES-1:0]  strobe_q;
   logic [DATA_W-1:0] rd_masked;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign be_d      = accept ? req_be : be_q;

   // Phase sequencing.
   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_IDLE:  if (req_valid) phase_d = req_write ? PH_SETUP : PH_READ;
         PH_READ:  if (phase_done) phase_d = PH_IDLE;
         PH_SETUP: if (phase_done) phase_d = PH_PULSE;
         PH_PULSE: if (phase_done) phase_d = PH_RECOV;
         PH_RECOV: if (phase_done) phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      case (phase_d)
         PH_READ:  tmr_val = CNT_W'(RD_CYC - 1);
         PH_SETUP: tmr_val = CNT_W'(WS_CYC - 1);
         PH_PULSE: tmr_val = CNT_W'(WP_CYC - 1);
         PH_RECOV: tmr_val = CNT_W'(REC_CYC - 1);
         default:  tmr_val = '0;
      endcase
   end

   assign tmr_load = (phase_d != phase_q);
   assign pins_d   = phase_pins(phase_d);

   sram_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (phase_done)
   );

   sram_lane_gate #(
      .LANES (LANES)
   ) u_lanes (
      .sel      (pins_d.sel),
      .lane_en  (be_d),
      .bus_in   (sram_dq_in),
      .strobe_n (strobe_d),
      .masked   (rd_masked)
   );

   // Registered pins: every memory-side control leaves a flop.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         pins_q   <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, sel: 1'b0, drive: 1'b0};
         strobe_q <= '1;
         addr_q   <= '0;
         wdata_q  <= '0;
         be_q     <= '0;
      end else begin
         phase_q  <= phase_d;
         pins_q   <= pins_d;
         strobe_q <= strobe_d;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
      end
   end

   // Read capture on the edge that closes the access phase.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= 1'b0;
         if (phase_q == PH_READ && phase_done) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_masked;
         end
      end
   end

   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign sram_dq_oe  = pins_q.drive;
   assign sram_ce_n   = pins_q.ce_n;
   assign sram_we_n   = pins_q.we_n;
   assign sram_oe_n   = pins_q.oe_n;
   assign sram_lane_n = strobe_q;
   assign rsp_valid   = rvalid_q;
   assign rsp_rdata   = rdata_q;

   // Width of each write-enable low run, for the pulse check.
   logic [CNT_W:0] we_low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         we_low_run <= '0;
      else if (!sram_we_n && we_low_run != '1)
         we_low_run <= we_low_run + 1'b1;
      else if (sram_we_n)
         we_low_run <= '0;
   end

   a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && (&sram_lane_n) && !sram_dq_oe));

   a_r6_write_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

   a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> $past(sram_oe_n));

   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));

   a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_low_run >= (CNT_W+1)'(WP_CYC)));

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r9_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !sram_ce_n) |=> (!sram_ce_n || req_ready));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RD  = 7;   // ceil(70/10)
   localparam int WS  = 3;   // max(1, ceil(30/10))
   localparam int WP  = 4;   // max(ceil(35/10), 7-3)
   localparam int REC = 1;   // max(1, 7-3-4)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [16:0] sram_addr;
   logic [15:0] sram_dq_out;
   logic        sram_dq_oe;
   logic [15:0] sram_dq_in;
   logic        sram_ce_n, sram_we_n, sram_oe_n;
   logic [1:0]  sram_lane_n;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_async_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n)
   );

   // Memory model: 256 words keyed by the low address byte.
   logic [15:0] mem [256];
   initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

   always @(posedge sram_we_n) begin
      if (rst_n && sram_ce_n === 1'b0) begin
         for (int i = 0; i < 2; i++)
            if (!sram_lane_n[i]) mem[sram_addr[7:0]][i*8 +: 8] <= sram_dq_out[i*8 +: 8];
      end
   end

   always_comb begin
      for (int i = 0; i < 2; i++)
         sram_dq_in[i*8 +: 8] = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_lane_n[i])
                                ? mem[sram_addr[7:0]][i*8 +: 8] : 8'hEE;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
         summary();
         $finish;
      end
   end

   task automatic do_write(input logic [16:0] a, input logic [1:0] be, input logic [15:0] d);
      int lat = 0, we_cnt = 0, first_we = -1;
      bit oe_ok = 1, drv_ok = 1, addr_ok = 1, lane_ok = 1;
      req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
      @(posedge clk); @(negedge clk);
      req_valid = 0; req_addr = ~a; req_wdata = ~d;
      while (!req_ready) begin
         if (!sram_oe_n) oe_ok = 0;
         if (sram_addr != a) addr_ok = 0;
         if (!sram_we_n) begin
            if (first_we < 0) first_we = lat;
            we_cnt++;
            if (!sram_dq_oe || sram_dq_out != d) drv_ok = 0;
            if (sram_lane_n != ~be) lane_ok = 0;
         end else if (lat < WS && sram_dq_oe) drv_ok = 0;
         @(negedge clk); lat++;
      end
      chk(first_we == WS, "R4 setup length", first_we, WS);
      chk(we_cnt == WP, "R8 pulse length", we_cnt, WP);
      chk(lat == WS + WP + REC, "R4 total write length", lat, WS + WP + REC);
      chk(oe_ok, "R6 oe high in write", oe_ok, 1);
      chk(drv_ok, "R6 driver window", drv_ok, 1);
      chk(addr_ok, "R7 address held", addr_ok, 1);
      chk(lane_ok, "R5 lane strobes", sram_lane_n, ~be);
   endtask

   task automatic do_read(input logic [16:0] a, input logic [1:0] be, input logic [15:0] exp,
                          input bit intrude);
      int lat = 0, we_seen = 0;
      bit drv_ok = 1;
      req_valid = 1; req_write = 0; req_addr = a; req_be = be;
      @(posedge clk); @(negedge clk);
      req_valid = 0;
      chk(!sram_ce_n && !sram_oe_n && sram_we_n, "R2 read pins",
          {sram_ce_n, sram_we_n, sram_oe_n}, 3'b010);
      chk(sram_lane_n == ~be, "R3 read strobes", sram_lane_n, ~be);
      while (!rsp_valid) begin
         if (intrude && lat == 2) begin
            req_valid = 1; req_write = 1; req_addr = a; req_be = 2'b11; req_wdata = 16'h0000;
         end
         if (intrude && lat == RD - 1) req_valid = 0;
         if (!sram_we_n) we_seen++;
         if (sram_dq_oe) drv_ok = 0;
         @(negedge clk); lat++;
         if (lat > 4 * RD) break;
      end
      chk(lat == RD, "R2 read latency", lat, RD);
      chk(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
      chk(drv_ok, "R6 no drive on read", drv_ok, 1);
      if (intrude) chk(we_seen == 0, "R9 busy request ignored", we_seen, 0);
      @(negedge clk);
      chk(!rsp_valid, "R10 single pulse", rsp_valid, 0);
      if (intrude) chk(req_ready && sram_ce_n, "R9 no start after busy", sram_ce_n, 1);
   endtask

   // {write, addr, be, wdata, expected read}
   localparam int NV = 10;
   localparam logic [51:0] VEC [NV] = '{
      {1'b1, 17'h10003, 2'b11, 16'hA5C3, 16'h0000},
      {1'b1, 17'h00010, 2'b11, 16'h1234, 16'h0000},
      {1'b1, 17'h00010, 2'b01, 16'hFF77, 16'h0000},
      {1'b1, 17'h00010, 2'b10, 16'h99AA, 16'h0000},
      {1'b0, 17'h10003, 2'b11, 16'h0000, 16'hA5C3},
      {1'b0, 17'h00010, 2'b11, 16'h0000, 16'h9977},
      {1'b0, 17'h00010, 2'b01, 16'h0000, 16'h0077},
      {1'b0, 17'h00010, 2'b10, 16'h0000, 16'h9900},
      {1'b1, 17'h000FE, 2'b10, 16'h5B00, 16'h0000},
      {1'b0, 17'h000FE, 2'b11, 16'h0000, 16'h5B00}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
      chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lane_n == 2'b11 && !sram_dq_oe,
          "R1 reset pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_lane_n, sram_dq_oe}, 6'b111110);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(sram_ce_n && req_ready, "R1 idle after reset", sram_ce_n, 1);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][51]) do_write(VEC[v][50:34], VEC[v][33:32], VEC[v][31:16]);
         else            do_read(VEC[v][50:34], VEC[v][33:32], VEC[v][15:0], 1'b0);
      end

      // R9: competing request while a read is busy, then confirm memory intact
      do_read(17'h00010, 2'b11, 16'h9977, 1'b1);
      do_read(17'h00010, 2'b11, 16'h9977, 1'b0);
      // R5: lane-1-only write leaves lane 0 of the untouched word intact
      do_write(17'h10003, 2'b10, 16'h3C00);
      do_read(17'h10003, 2'b11, 16'h3CC3, 1'b0);
      // R1: back to idle deselect
      @(negedge clk);
      chk(sram_ce_n && sram_lane_n == 2'b11, "R1 idle after traffic", sram_ce_n, 1);

      summary();
      $finish;
   end

endmodule